// File: doc/BRIEF.md
# Dual-Law Serial Clock Divider

This block makes the serial clock for an SPI shift engine out of the module clock. A 32-bit control word selects one of two division laws. The linear law divides by an even number, 2 × (N + 1), where N is an 8-bit field. The power-of-two law divides by 2^M, where M is a 4-bit field. The block drives a 50 % duty level `sclk_o`. It also drives a one-cycle strobe `tick_o` in every cycle in which that level has just changed, so the shift engine can launch and capture data on it.

All pins are plain control and status; no data stream passes through the block, so there is no valid/ready handshake. While `en_i` is low the divider stays cleared and `sclk_o` follows the requested idle level. A new control word is picked up only at the end of the half period in progress, so a change made while the block runs never produces a shortened pulse. Working out N or M from a target frequency is left to software.

Top module: `spi_sclk_divider`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `sclk_o` is 0 and `tick_o` is 0.
- R2: With bit 12 of the control word set (linear law), each half period of `sclk_o` lasts N+1 module-clock cycles. N is bits [7:0].
- R3: With the linear law and N = 0, `sclk_o` toggles on every module-clock edge, which is half the module clock.
- R4: With bit 12 clear (power-of-two law) and M ≥ 1, each half period lasts 2^(M-1) cycles. M is bits [11:8]. For M = 15 that is 16384 cycles.
- R5: With the power-of-two law and M = 0, the block divides by 2, so each half period lasts 1 cycle.
- R6: Bits [31:13] never affect the output. Bits [11:8] are ignored under the linear law, and bits [7:0] are ignored under the power-of-two law.
- R7: The control word is sampled only at the clock edge that ends a half period (or while disabled). A change made mid-half-period leaves the current half period at its old length, and the next half period uses the new length.
- R8: While `en_i` is low, the divider does not count and `tick_o` is 0. One cycle later `sclk_o` equals `idle_lvl_i`, whatever the control word holds.
- R9: After `en_i` rises, the first toggle of `sclk_o` appears one full half period after the first enabled edge, starting from the idle level. `tick_o` is high in exactly those cycles in which `sclk_o` differs from its value in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Divider run enable |
| idle_lvl_i | input | 1 | Level of `sclk_o` while the divider is off |
| ctrl_word_i | input | 32 | Control word: [7:0] N, [11:8] M, [12] law select (1 = linear) |
| sclk_o | output | 1 | Divided serial clock level |
| tick_o | output | 1 | One-cycle strobe in each cycle `sclk_o` has just changed |

## Verification
The bench counts the cycle of every strobe against a pattern computed from the laws above. This catches an off-by-one in either law, a power-of-two law that is shifted by M instead of M-1, and an M = 0 case that stalls instead of dividing by two. Control words carry junk in the unused field and the upper bits, so a decoder that reads the wrong field or ignores the law bit gives the wrong period. Two mid-run word changes, one longer and one shorter than the current count, expose a divider that compares against the live word: that design would cut the half period in progress or run its counter past the new limit. Disabled phases with the idle level set to 1 show whether the level follows the idle input and whether the first toggle after enable lands a full half period late.

// File: rtl/spidiv_pkg.sv
package spidiv_pkg;

  typedef enum logic {
    LAW_POW2   = 1'b0,
    LAW_LINEAR = 1'b1
  } law_e;

  // Counter width that holds the longest half period of either law.
  function automatic int cnt_width(input int lin_w, input int pow_w);
    int lin_bits;
    int pow_bits;
    lin_bits = lin_w + 1;
    pow_bits = (1 << pow_w) - 1;
    return (lin_bits > pow_bits) ? lin_bits : pow_bits;
  endfunction

endpackage

// File: rtl/spidiv_decode.sv
module spidiv_decode
  import spidiv_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  parameter int CNT_W = 15
) (
  input  logic             law_i,
  input  logic [LIN_W-1:0] lin_i,
  input  logic [POW_W-1:0] pow_i,
  output logic [CNT_W-1:0] half_o
);

  law_e law;
  assign law = law_e'(law_i);

  always_comb begin
    if (law == LAW_LINEAR) begin
      half_o = CNT_W'(lin_i) + CNT_W'(1);
    end else if (pow_i == '0) begin
      half_o = CNT_W'(1);
    end else begin
      half_o = CNT_W'(1) << (pow_i - POW_W'(1));
    end
  end

endmodule

// File: rtl/spidiv_counter.sv
module spidiv_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] half_new_i,
  output logic             wrap_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_q;

  assign wrap_o = en_i && ((cnt_q + CNT_W'(1)) == half_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      half_q <= CNT_W'(1);
    end else if (!en_i) begin
      cnt_q  <= '0;
      half_q <= half_new_i;
    end else if (wrap_o) begin
      cnt_q  <= '0;
      half_q <= half_new_i;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_BELOW_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < half_q);  // R2

  AST_HALF_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q != '0);  // R5

  AST_HALF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap_o) |=> $stable(half_q));  // R7

  AST_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);  // R8

endmodule

// File: rtl/spidiv_phase.sv
module spidiv_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic idle_i,
  input  logic wrap_i,
  output logic sclk_o,
  output logic tick_o
);

  logic sclk_q;
  logic tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      tick_q <= 1'b0;
    end else if (!en_i) begin
      sclk_q <= idle_i;
      tick_q <= 1'b0;
    end else begin
      sclk_q <= wrap_i ? ~sclk_q : sclk_q;
      tick_q <= wrap_i;
    end
  end

  assign sclk_o = sclk_q;
  assign tick_o = tick_q;

  AST_IDLE_WHILE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (sclk_q == $past(idle_i)) && !tick_q);  // R8

  AST_TICK_IS_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) |-> (tick_q == (sclk_q != $past(sclk_q))));  // R9

endmodule

// File: rtl/spi_sclk_divider.sv
module spi_sclk_divider
  import spidiv_pkg::*;
#(
  parameter int CTRL_W = 32,
  parameter int LIN_W  = 8,
  parameter int POW_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              idle_lvl_i,
  input  logic [CTRL_W-1:0] ctrl_word_i,
  output logic              sclk_o,
  output logic              tick_o
);

  localparam int LIN_LSB = 0;
  localparam int POW_LSB = LIN_LSB + LIN_W;
  localparam int SEL_BIT = POW_LSB + POW_W;
  localparam int CNT_W   = cnt_width(LIN_W, POW_W);

  logic [CNT_W-1:0] half_new;
  logic             wrap;
  logic             ctrl_unused;

  assign ctrl_unused = ^ctrl_word_i[CTRL_W-1:SEL_BIT+1];

  spidiv_decode #(
    .LIN_W (LIN_W),
    .POW_W (POW_W),
    .CNT_W (CNT_W)
  ) decode_i (
    .law_i  (ctrl_word_i[SEL_BIT]),
    .lin_i  (ctrl_word_i[LIN_LSB +: LIN_W]),
    .pow_i  (ctrl_word_i[POW_LSB +: POW_W]),
    .half_o (half_new)
  );

  spidiv_counter #(
    .CNT_W (CNT_W)
  ) counter_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .half_new_i (half_new),
    .wrap_o     (wrap)
  );

  spidiv_phase phase_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .idle_i (idle_lvl_i),
    .wrap_i (wrap),
    .sclk_o (sclk_o),
    .tick_o (tick_o)
  );

  AST_NO_TICK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);  // R8

endmodule

// File: tb/spi_sclk_divider_tb_top.sv
module spi_sclk_divider_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        idle = 1'b0;
  logic [31:0] word = '0;
  logic        sclk;
  logic        tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_sclk_divider dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .en_i        (en),
    .idle_lvl_i  (idle),
    .ctrl_word_i (word),
    .sclk_o      (sclk),
    .tick_o      (tick)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Linear law: bit 12 set, N in [7:0]. Power-of-two law: bit 12 clear, M in [11:8].
  function automatic logic [31:0] lin_word(input int n, input logic [31:0] junk);
    return (junk & 32'hFFFF_EF00) | 32'h0000_1000 | 32'(n & 8'hFF);
  endfunction

  function automatic logic [31:0] pow_word(input int m, input logic [31:0] junk);
    return (junk & 32'hFFFF_E0FF) | (32'(m & 4'hF) << 8);
  endfunction

  // Disabled at idle level, then enabled; expect the first tick after h1
  // cycles and then every h2 cycles. At cycle chg_at the word becomes chg_word.
  task automatic run_ticks(input logic [31:0] w, input logic lvl0, input int h1,
                           input int h2, input int n, input int chg_at,
                           input logic [31:0] chg_word, input string tag);
    int next_t;
    int seen;
    int bad;
    logic lvl;
    next_t = h1;
    seen = 0;
    bad = 0;
    lvl = lvl0;
    @(negedge clk);
    en = 1'b0;
    idle = lvl0;
    word = w;
    @(negedge clk);
    @(negedge clk);
    chk(sclk == lvl0, tag, "idle level before enable", int'(sclk), int'(lvl0));
    en = 1'b1;
    for (int k = 1; seen < n; k++) begin
      @(negedge clk);
      if (k == next_t) begin
        chk(tick == 1'b1 && sclk == ~lvl, tag, "tick/toggle at expected cycle",
            int'({tick, sclk}), int'({1'b1, ~lvl}));
        lvl = ~lvl;
        seen++;
        next_t += h2;
      end else if (tick || sclk != lvl) begin
        bad++;
      end
      if (k == chg_at) word = chg_word;
    end
    chk(bad == 0, tag, "cycles with spurious tick or level change", bad, 0);
    en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk(sclk == 1'b0 && tick == 1'b0, "R1", "outputs in reset", int'({sclk, tick}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk == 1'b0 && tick == 1'b0, "R1", "outputs after release", int'({sclk, tick}), 0);
  endtask

  task automatic t_linear;
    run_ticks(lin_word(3, '0), 1'b0, 4, 4, 4, -1, '0, "R2");
    run_ticks(lin_word(255, '0), 1'b0, 256, 256, 2, -1, '0, "R2");
    run_ticks(lin_word(0, '0), 1'b0, 1, 1, 6, -1, '0, "R3");
  endtask

  task automatic t_pow2;
    run_ticks(pow_word(1, '0), 1'b0, 1, 1, 4, -1, '0, "R4");
    run_ticks(pow_word(4, '0), 1'b0, 8, 8, 3, -1, '0, "R4");
    run_ticks(pow_word(15, '0), 1'b0, 16384, 16384, 2, -1, '0, "R4");
    run_ticks(pow_word(0, '0), 1'b0, 1, 1, 5, -1, '0, "R5");
  endtask

  task automatic t_ignored;
    run_ticks(lin_word(2, 32'hA5A5_EF00), 1'b0, 3, 3, 3, -1, '0, "R6");
    run_ticks(pow_word(2, 32'h5A5A_E0AB), 1'b0, 2, 2, 3, -1, '0, "R6");
  endtask

  task automatic t_change;
    run_ticks(lin_word(3, '0), 1'b0, 4, 2, 4, 1, lin_word(1, '0), "R7");
    run_ticks(lin_word(7, '0), 1'b0, 8, 2, 4, 5, pow_word(2, '0), "R7");
  endtask

  task automatic t_disabled;
    int bad;
    bad = 0;
    @(negedge clk);
    en = 1'b0;
    idle = 1'b1;
    word = lin_word(0, '0);
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      word = (k % 2 == 0) ? pow_word(0, '0) : lin_word(k, '0);
      @(negedge clk);
      if (sclk != 1'b1 || tick) bad++;
    end
    chk(bad == 0, "R8", "disabled cycles off idle or ticking", bad, 0);
    idle = 1'b0;
    @(negedge clk);
    chk(sclk == 1'b0, "R8", "level follows idle input", int'(sclk), 0);
    run_ticks(lin_word(4, '0), 1'b1, 5, 5, 3, -1, '0, "R9");
  endtask

  initial begin
    t_reset();
    t_linear();
    t_pow2();
    t_ignored();
    t_change();
    t_disabled();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule